// File: doc/BRIEF.md
# Smart Card Clock and Control Register

This block is the main control register of a smart card interface, together with the logic that drives the card-side pins. A host writes and reads one 8-bit register over a simple bus with an address, a write strobe, write data and read data. The block divides the system clock, nominally 24 MHz, to produce a card clock at one of four rates. It can park that clock at a chosen level and sets whether the card I/O line is driven or tristated.

Changes of rate, stop requests and restarts take effect only at a phase boundary of the card clock. A running phase always completes at the length it started with, so no high or low pulse is ever cut short. A warm reset bit holds the card reset line low while card power stays on. A cold reset bit is a sticky safe state. While it is set, card power is removed, the clock is parked low, reset is held low, I/O is an input and the LED is off. The rate and direction fields are also forced to their defaults. On entry the block emits a one-cycle clear pulse for the neighbouring interface registers. The state lasts until software writes the bit back to zero.

Top module: `sc_clk_ctrl`

## Requirements
- R1: After reset the register at address REG_ADDR (default 7) reads 0x12. bus_rdata is combinational and reads 0x00 whenever bus_addr is not REG_ADDR.
- R2: Field [5:4] sets the card clock half period. Codes 00, 01, 10 and 11 give 8, 4, 2 and 1 system cycles, so the full period is 16, 8, 4 or 2 cycles.
- R3: A new rate code is taken up only when the current card clock phase ends. The phase in progress keeps its old length.
- R4: While bit 3 is 1, the card clock parks at the level in bit 2 (0 = low, 1 = high). At each phase end it toggles only if it is not already at that level, and then it holds.
- R5: Clearing bit 3, or changing bit 2 while stopped, takes effect only at a phase end of the current half period.
- R6: Bit 1 sets I/O direction. 0 means card_io_oe = 1 (line driven) and 1 means card_io_oe = 0 (input).
- R7: While bit 7 is 1: card_pwr_n = 1, card_rst_n = 0, card_io_oe = 0, led_on = 0, and the card clock parks low.
- R8: While bit 7 is 1, field [5:4] is held at 01 and bit 1 at 1, whatever is written. clr_others is high for exactly one cycle, the first cycle in which bit 7 reads 1. The state persists until a write with bit 7 = 0.
- R9: While bit 0 is 1 and bit 7 is 0, card_rst_n = 0 and card_pwr_n = 0.
- R10: Bit 6 always reads 0, and writing 1 to it has no effect.
- R11: A read returns the current value of every field, including fields forced by cold reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| card_clk | output | 1 | Card clock |
| card_pwr_n | output | 1 | Card power enable, active low |
| card_rst_n | output | 1 | Card reset, active low |
| card_io_oe | output | 1 | 1 drives the card I/O line, 0 leaves it an input |
| led_on | output | 1 | Activity LED, high when active |
| clr_others | output | 1 | One-cycle clear for the other interface registers |

## Verification
The clock generator is run at each of the four rates, with the code changed while a phase is running. This separates a design that applies a new rate immediately from one that waits for the phase end. Stop requests are issued once with the clock already at the park level and once with it at the opposite level. The park level is then flipped while stopped, so an early toggle or a missing final edge shows up as a mismatch. Cold reset is entered with all bits written as 1 and then rewritten while active, which separates a register that forces its fields from one that only masks the pins.

// File: rtl/sc_clk_ctrl.sv
`timescale 1ns/1ps
module sc_clk_ctrl #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'd7,
  parameter int HALF0 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              card_clk,
  output logic              card_pwr_n,
  output logic              card_rst_n,
  output logic              card_io_oe,
  output logic              led_on,
  output logic              clr_others
);
  localparam int CW = $clog2(HALF0);
  localparam int HW = CW + 1;
  localparam logic [7:0] CTL_RST = 8'h12;

  logic [7:0]    ctl_q, ctl_d;
  logic          cold_d1;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] half_q;
  logic [HW-1:0] half_next;
  logic          clk_q;

  wire cold     = ctl_q[7];
  wire stop_req = cold | ctl_q[3];
  wire park_lvl = ~cold & ctl_q[2];
  wire tick     = (cnt_q == CW'(half_q - 1'b1));
  wire flip     = ~stop_req | (clk_q != park_lvl);

  assign half_next = HW'(HALF0 >> ctl_q[5:4]);

  always_comb begin
    ctl_d = (bus_wr && bus_addr == REG_ADDR) ? bus_wdata : ctl_q;
    ctl_d[6] = 1'b0;
    if (ctl_d[7]) begin
      ctl_d[5:4] = 2'b01;
      ctl_d[1]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RST;
      cold_d1 <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      cold_d1 <= cold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HW'(HALF0 >> 1);
      clk_q  <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      half_q <= half_next;
      if (flip) clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bus_rdata  = (bus_addr == REG_ADDR) ? ctl_q : 8'h00;
  assign card_clk   = clk_q;
  assign card_pwr_n = cold;
  assign card_rst_n = ~(cold | ctl_q[0]);
  assign card_io_oe = ~cold & ~ctl_q[1];
  assign led_on     = ~cold;
  assign clr_others = cold & ~cold_d1;

  AST_COLD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] |-> (card_pwr_n && !card_rst_n && !card_io_oe && !led_on)); // R7
  AST_COLD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] |-> (ctl_q[5:4] == 2'b01 && ctl_q[1])); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_others |=> !clr_others); // R8
  AST_BIT6_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !ctl_q[6]); // R10
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_req) && $past(card_clk) == $past(park_lvl)) |-> $stable(card_clk)); // R4
  AST_WARM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !ctl_q[7]) |-> (!card_rst_n && !card_pwr_n)); // R9
  AST_RATE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(half_q)); // R3
endmodule

// File: tb/sim_sc_clk_ctrl.sv
`timescale 1ns/1ps
module sim_sc_clk_ctrl;
  localparam int CLK_PERIOD = 42;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0] bus_addr = 3'd7;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic card_clk, card_pwr_n, card_rst_n, card_io_oe, led_on, clr_others;

  int checks = 0, errors = 0, cycles = 0;
  int m_reg, m_cnt, m_half, m_clk, m_cd;
  int m_cold, m_sreq, m_lvl, m_nxt;
  bit done = 0;

  sc_clk_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_clk(card_clk),
    .card_pwr_n(card_pwr_n), .card_rst_n(card_rst_n), .card_io_oe(card_io_oe),
    .led_on(led_on), .clr_others(clr_others));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 'h12; m_cnt = 0; m_half = 4; m_clk = 0; m_cd = 0;
    end else begin
      m_cold = (m_reg >> 7) & 1;
      m_sreq = m_cold | ((m_reg >> 3) & 1);
      m_lvl  = m_cold ? 0 : ((m_reg >> 2) & 1);
      if (m_cnt == m_half - 1) begin
        m_cnt = 0;
        m_half = 8 >> ((m_reg >> 4) & 3);
        if (!m_sreq || m_clk != m_lvl) m_clk = 1 - m_clk;
      end else m_cnt++;
      m_cd = m_cold;
      m_nxt = (bus_wr && bus_addr == 3'd7) ? int'(bus_wdata) : m_reg;
      m_nxt = m_nxt & 'hBF;
      if (m_nxt & 'h80) m_nxt = (m_nxt & ~'h32) | 'h12;
      m_reg = m_nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk("R2 R3 R4 R5 card_clk", int'(card_clk), m_clk);
      chk("R7 card_pwr_n", int'(card_pwr_n), (m_reg >> 7) & 1);
      chk("R7 R9 card_rst_n", int'(card_rst_n), ((m_reg & 'h81) != 0) ? 0 : 1);
      chk("R6 R7 card_io_oe", int'(card_io_oe), ((m_reg & 'h82) == 0) ? 1 : 0);
      chk("R7 led_on", int'(led_on), ((m_reg >> 7) & 1) ^ 1);
      chk("R8 clr_others", int'(clr_others), (((m_reg >> 7) & 1) == 1 && m_cd == 0) ? 1 : 0);
      chk("R1 R10 R11 bus_rdata", int'(bus_rdata), (bus_addr == 3'd7) ? m_reg : 0);
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #2;
    bus_wr = 1; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 0;
  endtask

  task automatic measure(input int exp);
    int n = 0;
    @(negedge clk);
    while (card_clk !== 1'b0) @(negedge clk);
    while (card_clk !== 1'b1) @(negedge clk);
    @(negedge clk); n = 1;
    while (card_clk !== 1'b0) begin @(negedge clk); n++; end
    while (card_clk !== 1'b1) begin @(negedge clk); n++; end
    chk("R2 period", n, exp);
  endtask

  initial begin
    idle(5);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset value", int'(bus_rdata), 'h12);
    chk("R1 reset clk", int'(card_clk), 0);
    chk("R1 reset led", int'(led_on), 1);
    idle(1); bus_addr = 3'd3;
    @(negedge clk); chk("R1 other address", int'(bus_rdata), 0);
    idle(1); bus_addr = 3'd7;
    idle(30);
    for (int c = 0; c < 4; c++) begin
      wr(8'((c << 4) | 'h02));
      idle(40);
      measure(16 >> c);
    end
    wr(8'h32); idle(3); wr(8'h02); idle(3); wr(8'h22); idle(30);
    wr(8'h1A); idle(30);
    @(negedge clk); chk("R4 parked low", int'(card_clk), 0);
    wr(8'h1E); idle(30);
    @(negedge clk); chk("R4 R5 parked high", int'(card_clk), 1);
    wr(8'h0E); idle(1); wr(8'h0A); idle(30);
    @(negedge clk); chk("R4 park low slow", int'(card_clk), 0);
    wr(8'h32); idle(20);
    wr(8'h30);
    @(negedge clk); chk("R6 output mode", int'(card_io_oe), 1);
    wr(8'h32);
    @(negedge clk); chk("R6 input mode", int'(card_io_oe), 0);
    wr(8'h33);
    @(negedge clk); chk("R9 warm rst", int'(card_rst_n), 0);
    chk("R9 warm power", int'(card_pwr_n), 0);
    wr(8'h36); idle(10);
    wr(8'hFF);
    @(negedge clk); chk("R8 R11 cold readback", int'(bus_rdata), 'h9F);
    chk("R7 cold power", int'(card_pwr_n), 1);
    idle(30);
    @(negedge clk); chk("R7 cold clock low", int'(card_clk), 0);
    wr(8'hB0);
    @(negedge clk); chk("R8 forced fields", int'(bus_rdata), 'h92);
    idle(10);
    wr(8'h00);
    @(negedge clk); chk("R8 cold released", int'(bus_rdata), 'h00);
    chk("R8 power back", int'(card_pwr_n), 0);
    wr(8'h40);
    @(negedge clk); chk("R10 bit6 ignored", int'(bus_rdata), 'h00);
    wr(8'h7F);
    @(negedge clk); chk("R10 bit6 masked", int'(bus_rdata), 'h3F);
    idle(40);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule